// File: doc/BRIEF.md
# Debug Serial Port Register Front End

This block is the register side of a small debug serial port. A processor reaches it over a 32-bit bus with byte offsets on word boundaries. Through it the processor turns the receiver and transmitter on and off, reads received bytes, writes bytes for transmission and sets a baud divisor. It also controls which status conditions raise a single level interrupt, and it can read two fixed identification words. A separate serializer handles the bit timing on the line. This block sends that serializer a one-cycle byte strobe, takes back a "byte finished" pulse, and accepts received bytes together with their parity and framing error qualifiers.

Reads return data in the same cycle the address is presented. Every write takes effect at the clock edge that samples it. The status flags and the interrupt react to bus accesses and to serializer events one edge later.

Top module: `dbg_uart_regs`

## Requirements
- R1: After reset the receiver and transmitter are off. Mode, mask, divisor and storage read 0. Status reads 0x00000A02, meaning transmit ready (bit 1), transmitter empty (bit 9) and transmit buffer empty (bit 11) are set. The identification word reads the ID_WORD parameter, 0x275B0940 by default. `irq`, `rx_ready` and `tx_valid` are low.
- R2: The byte offsets are decoded from address bits 8:2, with bits 1:0 and every bit above 8 ignored, so the map repeats every 0x200. Mode (0x04) and storage (0x48) are 32-bit read/write. The divisor (0x20) holds 16 bits and reads zero-extended. Offsets 0x00, 0x08, 0x0C and 0x1C read 0, and any offset not named in R1–R13 reads 0. Writes to the mask (0x10), status (0x14), receive (0x18), identification (0x40, 0x44) and unnamed offsets change nothing.
- R3: A write to control (0x00) acts on the receiver through bit 4 (on) and bit 5 (off), and on the transmitter through bit 6 (on) and bit 7 (off). When both bits for one direction are set, the off command wins. A direction with neither bit set keeps its state.
- R4: A control write with bit 8 set clears status bits 5 (overrun), 6 (framing) and 7 (parity) and leaves every other status bit unchanged.
- R5: A write to 0x08 ORs the data into the mask. A write to 0x0C clears the mask bits that are set in the data. The mask reads at 0x10.
- R6: `irq` is high exactly when status AND mask is nonzero. It follows any change to either register on the next edge.
- R7: `rx_ready` is high when the receiver is on and status bit 0 is clear. A `rx_valid` pulse in that state loads `rx_data` into the receive register (0x18, low byte) and sets status bits 0 and 12.
- R8: An accepted byte with `rx_perr` set also sets status bit 7, and one with `rx_ferr` set also sets bit 6. A `rx_valid` pulse while the receiver is on and bit 0 is set is dropped and sets bit 5. A pulse while the receiver is off has no effect at all.
- R9: A read of 0x18 returns the held byte and clears status bits 0 and 12. A byte accepted in the same cycle sets them again.
- R10: A write to 0x1C while the transmitter is on and status bit 1 is set produces `tx_valid` for exactly one cycle after the write edge, with `tx_data` equal to the low data byte. The same write clears status bits 1 and 9 and leaves bit 11 set.
- R11: A write to 0x1C while the transmitter is off, or while status bit 1 is clear, causes no `tx_valid` pulse and no status change.
- R12: A `tx_done` pulse sets status bits 1 and 9. An accepted write to 0x1C in the same cycle overrides it.
- R13: Offset 0x44 reads the ID_EXT_WORD parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | One-cycle strobe: byte for the serializer |
| tx_data | output | 8 | Byte to transmit |
| tx_done | input | 1 | Serializer finished the byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Received byte had a parity error |
| rx_ferr | input | 1 | Received byte had a framing error |
| rx_ready | output | 1 | Receiver can take a byte |

## Verification
Read data is combinational, so the bench compares `bus_rdata` 1 ns after it drives a read address, before the edge that performs the read's side effect. Register updates, the status flags, `irq`, `rx_ready` and `tx_valid` all change at the edge that samples the access or the serializer pulse. The bench therefore checks them 1 ns after that edge, against a model it has advanced by one step for the same inputs. A `tx_valid` pulse is expected in exactly that one sample and absent in the next, and a rejected transmit write is confirmed there by a low strobe and an unchanged status read.

// File: rtl/dbg_uart_regs.sv
`timescale 1ns/1ps
module dbg_uart_regs #(
  parameter int          ADDR_W      = 12,
  parameter int          SPAN_W      = 9,
  parameter int          DIV_W       = 16,
  parameter logic [31:0] ID_WORD     = 32'h275B0940,
  parameter logic [31:0] ID_EXT_WORD = 32'h00000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_done,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  output logic              rx_ready
);
  localparam logic [SPAN_W-1:0] A_CTRL = SPAN_W'('h00);
  localparam logic [SPAN_W-1:0] A_MODE = SPAN_W'('h04);
  localparam logic [SPAN_W-1:0] A_MSET = SPAN_W'('h08);
  localparam logic [SPAN_W-1:0] A_MCLR = SPAN_W'('h0C);
  localparam logic [SPAN_W-1:0] A_MASK = SPAN_W'('h10);
  localparam logic [SPAN_W-1:0] A_STAT = SPAN_W'('h14);
  localparam logic [SPAN_W-1:0] A_RXD  = SPAN_W'('h18);
  localparam logic [SPAN_W-1:0] A_TXD  = SPAN_W'('h1C);
  localparam logic [SPAN_W-1:0] A_DIV  = SPAN_W'('h20);
  localparam logic [SPAN_W-1:0] A_ID   = SPAN_W'('h40);
  localparam logic [SPAN_W-1:0] A_IDX  = SPAN_W'('h44);
  localparam logic [SPAN_W-1:0] A_STOR = SPAN_W'('h48);

  localparam int S_RXRDY = 0;
  localparam int S_TXRDY = 1;
  localparam int S_OVR   = 5;
  localparam int S_FRM   = 6;
  localparam int S_PAR   = 7;
  localparam int S_TXEMP = 9;
  localparam int S_TXBE  = 11;
  localparam int S_RXFUL = 12;
  localparam logic [31:0] SR_RST = (32'd1 << S_TXRDY) | (32'd1 << S_TXEMP) | (32'd1 << S_TXBE);

  localparam int C_RXON  = 4;
  localparam int C_RXOFF = 5;
  localparam int C_TXON  = 6;
  localparam int C_TXOFF = 7;
  localparam int C_CLRST = 8;

  logic             rx_en_q, tx_en_q;
  logic [31:0]      mode_q, imr_q, sr_q, stor_q;
  logic [7:0]       rhr_q;
  logic [DIV_W-1:0] div_q;
  logic [31:0]      sr_d;

  wire [SPAN_W-1:0] ofs = {bus_addr[SPAN_W-1:2], 2'b00};
  wire wr  = bus_sel & bus_wr;
  wire rd  = bus_sel & ~bus_wr;

  wire we_ctrl = wr & (ofs == A_CTRL);
  wire we_thr  = wr & (ofs == A_TXD);
  wire rd_rhr  = rd & (ofs == A_RXD);
  wire thr_go  = we_thr & tx_en_q & sr_q[S_TXRDY];

  assign rx_ready = rx_en_q & ~sr_q[S_RXRDY];
  wire rx_take = rx_valid & rx_ready;
  wire rx_lost = rx_valid & rx_en_q & sr_q[S_RXRDY];

  assign irq = |(sr_q & imr_q);

  always_comb begin
    sr_d = sr_q;
    if (we_ctrl && bus_wdata[C_CLRST]) begin
      sr_d[S_OVR] = 1'b0;
      sr_d[S_FRM] = 1'b0;
      sr_d[S_PAR] = 1'b0;
    end
    if (rd_rhr) begin
      sr_d[S_RXRDY] = 1'b0;
      sr_d[S_RXFUL] = 1'b0;
    end
    if (tx_done) begin
      sr_d[S_TXRDY] = 1'b1;
      sr_d[S_TXEMP] = 1'b1;
    end
    if (thr_go) begin
      sr_d[S_TXRDY] = 1'b0;
      sr_d[S_TXEMP] = 1'b0;
    end
    if (rx_take) begin
      sr_d[S_RXRDY] = 1'b1;
      sr_d[S_RXFUL] = 1'b1;
      if (rx_perr) sr_d[S_PAR] = 1'b1;
      if (rx_ferr) sr_d[S_FRM] = 1'b1;
    end
    if (rx_lost) sr_d[S_OVR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q  <= 1'b0;
      tx_en_q  <= 1'b0;
      mode_q   <= '0;
      imr_q    <= '0;
      sr_q     <= SR_RST;
      stor_q   <= '0;
      rhr_q    <= '0;
      div_q    <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      sr_q     <= sr_d;
      tx_valid <= thr_go;
      if (thr_go) tx_data <= bus_wdata[7:0];
      if (rx_take) rhr_q <= rx_data;
      if (we_ctrl) begin
        if (bus_wdata[C_RXOFF])     rx_en_q <= 1'b0;
        else if (bus_wdata[C_RXON]) rx_en_q <= 1'b1;
        if (bus_wdata[C_TXOFF])     tx_en_q <= 1'b0;
        else if (bus_wdata[C_TXON]) tx_en_q <= 1'b1;
      end
      if (wr) begin
        unique case (ofs)
          A_MODE:  mode_q <= bus_wdata;
          A_MSET:  imr_q  <= imr_q | bus_wdata;
          A_MCLR:  imr_q  <= imr_q & ~bus_wdata;
          A_DIV:   div_q  <= bus_wdata[DIV_W-1:0];
          A_STOR:  stor_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (ofs)
      A_MODE:  bus_rdata = mode_q;
      A_MASK:  bus_rdata = imr_q;
      A_STAT:  bus_rdata = sr_q;
      A_RXD:   bus_rdata = {24'd0, rhr_q};
      A_DIV:   bus_rdata = 32'(div_q);
      A_ID:    bus_rdata = ID_WORD;
      A_IDX:   bus_rdata = ID_EXT_WORD;
      A_STOR:  bus_rdata = stor_q;
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/dbg_uart_regs_chk.sv
`timescale 1ns/1ps
module dbg_uart_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int SPAN_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              rx_valid,
  input logic              tx_valid,
  input logic              rx_en_q,
  input logic              tx_en_q,
  input logic [31:0]       sr_q,
  input logic [31:0]       imr_q,
  input logic [7:0]        rhr_q
);
  wire [SPAN_W-1:0] o = {bus_addr[SPAN_W-1:2], 2'b00};
  wire w_ctrl = bus_sel && bus_wr && o == SPAN_W'('h00);
  wire w_set  = bus_sel && bus_wr && o == SPAN_W'('h08);
  wire w_clr  = bus_sel && bus_wr && o == SPAN_W'('h0C);
  wire w_thr  = bus_sel && bus_wr && o == SPAN_W'('h1C);
  wire r_rhr  = bus_sel && !bus_wr && o == SPAN_W'('h18);

  assert_rx_off_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && bus_wdata[5]) |=> !rx_en_q);
  assert_tx_off_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && bus_wdata[7]) |=> !tx_en_q);
  assert_err_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && bus_wdata[8] && !rx_valid) |=> (sr_q[7:5] == 3'b000));
  assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    w_set |=> ((imr_q & $past(bus_wdata)) == $past(bus_wdata)));
  assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    w_clr |=> ((imr_q & $past(bus_wdata)) == 32'd0));
  assert_rx_off_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_en_q) |=> $stable(rhr_q));
  assert_rhr_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rhr && !rx_valid) |=> (!sr_q[0] && !sr_q[12]));
  assert_tx_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);
  assert_tx_off_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (w_thr && !tx_en_q) |=> !tx_valid);
endmodule

bind dbg_uart_regs dbg_uart_regs_chk #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rx_valid(rx_valid), .tx_valid(tx_valid),
  .rx_en_q(rx_en_q), .tx_en_q(tx_en_q), .sr_q(sr_q), .imr_q(imr_q), .rhr_q(rhr_q)
);

// File: tb/dbg_uart_regs_tb_top.sv
`timescale 1ns/1ps
module dbg_uart_regs_tb_top;
  localparam logic [31:0] IDW  = 32'h275B0940;
  localparam logic [31:0] IDXW = 32'h13579BDF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, tx_done = 0, rx_valid = 0, rx_perr = 0, rx_ferr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  rx_data = '0;
  logic [31:0] bus_rdata;
  logic irq, tx_valid, rx_ready;
  logic [7:0] tx_data;

  always #2.5 clk = ~clk;

  dbg_uart_regs #(.ID_EXT_WORD(IDXW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_done(tx_done), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ready(rx_ready)
  );

  int nvec = 0, nbad = 0;
  bit done = 0;
  string force_tag = "";

  logic        m_rxen = 0, m_txen = 0, m_txv = 0;
  logic [31:0] m_mode = 0, m_imr = 0, m_sr = 32'h0A02, m_stor = 0;
  logic [7:0]  m_rhr = 0, m_txd = 0;
  logic [15:0] m_div = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [8:0] o);
    case (o)
      9'h04: return m_mode;
      9'h10: return m_imr;
      9'h14: return m_sr;
      9'h18: return {24'd0, m_rhr};
      9'h20: return {16'd0, m_div};
      9'h40: return IDW;
      9'h44: return IDXW;
      9'h48: return m_stor;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string read_tag(input logic [8:0] o);
    case (o)
      9'h10: return "R5";
      9'h14: return "R7";
      9'h18: return "R9";
      9'h44: return "R13";
      default: return "R2";
    endcase
  endfunction

  task automatic step(input logic s, input logic w, input logic [11:0] a, input logic [31:0] d,
                      input logic rv, input logic [7:0] rb, input logic pe, input logic fe,
                      input logic td);
    logic [8:0] o;
    logic [31:0] n_sr, n_imr;
    logic n_rxen, n_txen, take, lost, go;
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    rx_valid = rv; rx_data = rb; rx_perr = pe; rx_ferr = fe; tx_done = td;
    o = {a[8:2], 2'b00};
    #1;
    if (s && !w) chk(bus_rdata, model_read(o), force_tag != "" ? force_tag : read_tag(o));
    n_sr = m_sr; n_imr = m_imr; n_rxen = m_rxen; n_txen = m_txen;
    take = rv && m_rxen && !m_sr[0];
    lost = rv && m_rxen && m_sr[0];
    go   = s && w && o == 9'h1C && m_txen && m_sr[1];
    if (s && w) begin
      case (o)
        9'h00: begin
          if (d[5]) n_rxen = 0; else if (d[4]) n_rxen = 1;
          if (d[7]) n_txen = 0; else if (d[6]) n_txen = 1;
          if (d[8]) n_sr[7:5] = 3'b000;
        end
        9'h04: m_mode = d;
        9'h08: n_imr = m_imr | d;
        9'h0C: n_imr = m_imr & ~d;
        9'h20: m_div = d[15:0];
        9'h48: m_stor = d;
        default: ;
      endcase
    end
    if (s && !w && o == 9'h18) begin n_sr[0] = 0; n_sr[12] = 0; end
    if (td) begin n_sr[1] = 1; n_sr[9] = 1; end
    if (go) begin n_sr[1] = 0; n_sr[9] = 0; m_txd = d[7:0]; end
    if (take) begin
      n_sr[0] = 1; n_sr[12] = 1; m_rhr = rb;
      if (pe) n_sr[7] = 1;
      if (fe) n_sr[6] = 1;
    end
    if (lost) n_sr[5] = 1;
    m_sr = n_sr; m_imr = n_imr; m_rxen = n_rxen; m_txen = n_txen; m_txv = go;
    @(posedge clk);
    #1;
    chk({31'd0, tx_valid}, {31'd0, m_txv}, go ? "R10" : "R11");
    if (m_txv) chk({24'd0, tx_data}, {24'd0, m_txd}, "R10");
    chk({31'd0, irq}, {31'd0, |(m_sr & m_imr)}, "R6");
    chk({31'd0, rx_ready}, {31'd0, m_rxen & ~m_sr[0]}, "R7");
    bus_sel = 0; bus_wr = 0; rx_valid = 0; rx_perr = 0; rx_ferr = 0; tx_done = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1, 1, a, d, 0, 8'h00, 0, 0, 0);
  endtask
  task automatic rd(input logic [11:0] a);
    step(1, 0, a, 32'h0, 0, 8'h00, 0, 0, 0);
  endtask
  task automatic rx(input logic [7:0] b, input logic pe, input logic fe);
    step(0, 0, 12'h0, 32'h0, 1, b, pe, fe, 0);
  endtask

  localparam int NOFS = 16;
  logic [8:0] ofs_tab [NOFS] = '{9'h00, 9'h04, 9'h08, 9'h0C, 9'h10, 9'h14, 9'h18, 9'h1C,
                                 9'h20, 9'h40, 9'h44, 9'h48, 9'h24, 9'h30, 9'h4C, 9'h1FC};

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    force_tag = "R1";
    chk({29'd0, irq, rx_ready, tx_valid}, 32'd0, "R1");
    rd(12'h014); rd(12'h040); rd(12'h010); rd(12'h020); rd(12'h004); rd(12'h048);
    force_tag = "";

    wr(12'h000, 32'h30);            // R3 off beats on: rx_ready stays low
    wr(12'h000, 32'h10);            // R3 receiver on
    wr(12'h000, 32'hC0);            // R3 transmitter off beats on
    wr(12'h01C, 32'h55);            // R11 ignored while off
    rd(12'h014);
    wr(12'h000, 32'h40);
    wr(12'h01C, 32'h1A5);           // R10 strobe with A5
    rd(12'h014);
    wr(12'h01C, 32'h33);            // R11 ignored while busy
    step(0, 0, 12'h0, 0, 0, 8'h0, 0, 0, 1); // R12 done
    rd(12'h014);
    rx(8'hC3, 1, 1);                // R7 R8 accept with errors
    rx(8'h11, 0, 0);                // R8 overrun, byte dropped
    rd(12'h014);
    wr(12'h008, 32'h80);            // R5 R6 irq from parity
    wr(12'h000, 32'h100);           // R4 clear errors only
    rd(12'h014);
    wr(12'h008, 32'h1001);
    wr(12'h00C, 32'h1000);
    rd(12'h010);
    rd(12'h018);                    // R9 read clears flags
    rd(12'h014);
    wr(12'h010, 32'hFFFF_FFFF);     // R2 mask is read-only
    wr(12'h014, 32'hFFFF_FFFF);     // R2 status is read-only
    rd(12'h010); rd(12'h014);
    wr(12'h204, 32'hDEAD_BEEF);     // R2 alias
    rd(12'h004);
    wr(12'h020, 32'hABCD_1234);     // R2 divisor width
    rd(12'h020);
    rd(12'h030); rd(12'h044);       // R2 R13
    wr(12'h000, 32'h20);
    rx(8'h77, 0, 0);                // R8 receiver off: no effect
    rd(12'h018); rd(12'h014);

    for (int i = 0; i < 6000; i++) begin
      logic [8:0] o;
      logic [31:0] d;
      logic s, w, rv, td;
      o = ofs_tab[$urandom_range(NOFS-1)];
      s = ($urandom_range(9) < 7);
      w = $urandom_range(1);
      d = $urandom;
      if (o == 9'h00) d = d & 32'h1F0;
      rv = ($urandom_range(3) == 0);
      td = m_sr[1] ? ($urandom_range(19) == 0) : ($urandom_range(3) == 0);
      step(s, w, {3'($urandom_range(7)), o}, d, rv, 8'($urandom), $urandom_range(1),
           $urandom_range(1), td);
    end

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nvec++; nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule